// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog made of a base counter followed by a power-of-two postscaler. Both advance on a slow, always-on tick strobe that arrives as a single-cycle enable on the system clock. When the count runs out, the block decides where the event goes by looking at the current power mode. While the processor is executing code, the event becomes a reset request. While the processor is idle or asleep, the event becomes a wake request for the mode sequencer, and no reset is issued.

Software restarts the count with a clear strobe. Several system events also restart it: entry into sleep, loss of the selected clock (when the fail-safe monitor is enabled), and a write to the internal oscillator's frequency select while that oscillator drives the system. A separate output tells the clock logic to keep the slow oscillator running whenever the watchdog or the fail-safe monitor is enabled.

Top module: `mode_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `wdt_rst_req`, `wake_req` and `lf_keep_on` are low and the count is zero.
- R2: Counting from zero, a time-out occurs on the lf_tick that completes 2^(BASE_W+n) ticks. Here n is the unsigned value of the 4-bit field `ps_sel` (0 to 15). Cycles without `lf_tick` do not advance the count.
- R3: A time-out while `pm_mode` is 2'b00 (run) drives `wdt_rst_req` high in the cycle after the tick edge, and `wake_req` stays low.
- R4: A time-out while `pm_mode` is 2'b01 (idle), 2'b10 (sleep) or 2'b11 (doze, treated as not executing) drives `wake_req` high in the cycle after the tick edge, and `wdt_rst_req` stays low.
- R5: Each request is a single-cycle pulse. After a time-out, the count restarts from zero, so the next time-out comes one full period later.
- R6: `clrwd_stb` clears the base counter and the postscaler.
- R7: `sleep_stb` clears the base counter and the postscaler.
- R8: `clk_lost` clears both counters when `fscm_en` is high. When `fscm_en` is low, `clk_lost` is ignored and the count continues.
- R9: `freq_wr_stb` clears both counters.
- R10: A clear that falls on the same cycle as a time-out tick wins: no request is issued, and the count restarts from zero.
- R11: While `wdt_en` is low, the count is held at zero and no request is issued. After enable, a full period is needed before a time-out.
- R12: If `ps_sel` is lowered below the progress already made, the time-out occurs at the next wrap of the base counter.
- R13: `lf_keep_on` equals `wdt_en | fscm_en`, registered by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdt_en | input | 1 | Watchdog enable |
| fscm_en | input | 1 | Fail-safe clock monitor enabled |
| lf_tick | input | 1 | Single-cycle strobe from the slow always-on clock |
| pm_mode | input | 2 | Power mode: 00 run, 01 idle, 10 sleep, 11 doze |
| ps_sel | input | SEL_W | Postscaler exponent n, ratio 2^n |
| clrwd_stb | input | 1 | Software clear strobe |
| sleep_stb | input | 1 | Sleep entry strobe |
| clk_lost | input | 1 | Selected clock lost, from the fail-safe monitor |
| freq_wr_stb | input | 1 | Internal oscillator frequency select written while it is the system clock |
| wdt_rst_req | output | 1 | Watchdog reset request pulse |
| wake_req | output | 1 | Wake request pulse to the mode sequencer |
| lf_keep_on | output | 1 | Keep the slow oscillator running |

## Verification
A wrong base count or postscaler value shows up as a request pulse on the wrong cycle, early or late by at least one tick. The first time-out after the fault exposes it, at most 2^(BASE_W+n) ticks later. A clear that is dropped or ignored by mistake also shifts the next pulse by the number of ticks that had already elapsed. Wrong mode routing shows in the same cycle as the time-out, on the wrong output pin. The bench model therefore tracks ticks since the last restart and compares both pulse outputs every cycle.

// File: rtl/mwdt_pkg.sv
package mwdt_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10,
        PM_DOZE  = 2'b11
    } pm_mode_e;

    typedef struct packed {
        logic sw;
        logic sleep;
        logic clk_loss;
        logic freq;
    } clr_src_t;

    function automatic logic code_running(input pm_mode_e m);
        return (m == PM_RUN);
    endfunction

endpackage

// File: rtl/mwdt_clear_ctrl.sv
module mwdt_clear_ctrl
    import mwdt_pkg::*;
(
    input  logic clrwd_i,
    input  logic sleep_i,
    input  logic clk_lost_i,
    input  logic fscm_en_i,
    input  logic freq_wr_i,
    output logic clr_o
);
    clr_src_t src;

    always_comb begin
        src.sw       = clrwd_i;
        src.sleep    = sleep_i;
        // clock loss only counts when the monitor is on (R8)
        src.clk_loss = clk_lost_i & fscm_en_i;
        src.freq     = freq_wr_i;
        clr_o        = |src;
    end

endmodule

// File: rtl/mwdt_count.sv
module mwdt_count #(
    parameter int BASE_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             clr_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             timeout_o
);
    localparam int POST_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [POST_W-1:0] post;
        logic [BASE_W-1:0] base;
    } cnt_t;

    cnt_t              st_d, st_q;
    logic [POST_W-1:0] term;
    logic              base_full;

    always_comb begin
        for (int i = 0; i < POST_W; i++) begin
            term[i] = (i < int'(sel_i));
        end
        base_full = (st_q.base == '1);
        st_d      = st_q;
        timeout_o = 1'b0;
        if (!en_i || clr_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (base_full) begin
                if (st_q.post >= term) begin
                    st_d      = '0;
                    timeout_o = 1'b1;
                end else begin
                    st_d.base = '0;
                    st_d.post = st_q.post + 1'b1;
                end
            end else begin
                st_d.base = st_q.base + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r11_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q == '0));
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q == '0));
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> (st_q == '0));
    a_r2_post_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !(tick_i && base_full)) |=> $stable(st_q.post));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && !tick_i) |=> $stable(st_q));

endmodule

// File: rtl/mwdt_route.sv
module mwdt_route
    import mwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timeout_i,
    input  logic [1:0] mode_i,
    input  logic       keep_i,
    output logic       rst_req_o,
    output logic       wake_req_o,
    output logic       keep_o
);
    typedef struct packed {
        logic rst_req;
        logic wake_req;
        logic keep;
    } rt_t;

    rt_t  r_d, r_q;
    logic running;

    always_comb begin
        running    = code_running(pm_mode_e'(mode_i));
        r_d.rst_req  = timeout_i & running;
        r_d.wake_req = timeout_i & ~running;
        r_d.keep     = keep_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rst_req_o  = r_q.rst_req;
    assign wake_req_o = r_q.wake_req;
    assign keep_o     = r_q.keep;

    a_r3_run_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && mode_i == 2'b00) |=> (rst_req_o && !wake_req_o));
    a_r4_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && mode_i != 2'b00) |=> (wake_req_o && !rst_req_o));
    a_r5_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    a_r5_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |=> !wake_req_o);
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req_o, wake_req_o}));
    a_r13_keep: assert property (@(posedge clk) disable iff (!rst_n)
        keep_i |=> keep_o);

endmodule

// File: rtl/mode_watchdog.sv
module mode_watchdog #(
    parameter int BASE_W = 4,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en,
    input  logic             fscm_en,
    input  logic             lf_tick,
    input  logic [1:0]       pm_mode,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             clrwd_stb,
    input  logic             sleep_stb,
    input  logic             clk_lost,
    input  logic             freq_wr_stb,
    output logic             wdt_rst_req,
    output logic             wake_req,
    output logic             lf_keep_on
);
    logic clr;
    logic timeout;

    mwdt_clear_ctrl u_clr (
        .clrwd_i    (clrwd_stb),
        .sleep_i    (sleep_stb),
        .clk_lost_i (clk_lost),
        .fscm_en_i  (fscm_en),
        .freq_wr_i  (freq_wr_stb),
        .clr_o      (clr)
    );

    mwdt_count #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (wdt_en),
        .tick_i    (lf_tick),
        .clr_i     (clr),
        .sel_i     (ps_sel),
        .timeout_o (timeout)
    );

    mwdt_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .timeout_i  (timeout),
        .mode_i     (pm_mode),
        .keep_i     (wdt_en | fscm_en),
        .rst_req_o  (wdt_rst_req),
        .wake_req_o (wake_req),
        .keep_o     (lf_keep_on)
    );

    a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> (!wdt_rst_req && !wake_req));
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clrwd_stb || sleep_stb || freq_wr_stb) |=> (!wdt_rst_req && !wake_req));
    a_r1_no_tick_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !lf_tick |=> (!wdt_rst_req && !wake_req));

endmodule

// File: tb/mode_watchdog_test.sv
`timescale 1ns/1ps
module mode_watchdog_test;
    localparam int BW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en = 1'b0, fscm_en = 1'b0, lf_tick = 1'b0;
    logic [1:0] pm_mode = 2'b00;
    logic [3:0] ps_sel = 4'd0;
    logic       clrwd_stb = 1'b0, sleep_stb = 1'b0, clk_lost = 1'b0, freq_wr_stb = 1'b0;
    logic       wdt_rst_req, wake_req, lf_keep_on;

    int checks = 0;
    int errors = 0;
    int cnt = 0;
    int seed_sink;

    always #4 clk = ~clk;

    mode_watchdog #(.BASE_W(BW), .SEL_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .fscm_en(fscm_en),
        .lf_tick(lf_tick), .pm_mode(pm_mode), .ps_sel(ps_sel),
        .clrwd_stb(clrwd_stb), .sleep_stb(sleep_stb), .clk_lost(clk_lost),
        .freq_wr_stb(freq_wr_stb), .wdt_rst_req(wdt_rst_req),
        .wake_req(wake_req), .lf_keep_on(lf_keep_on)
    );

    function automatic bit fires(input int c, input int n);
        return (((c + 1) % (1 << BW)) == 0) && ((c + 1) >= (1 << (BW + n)));
    endfunction

    task automatic chk(input string tag, input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // inputs are stable here (driven after a falling edge); model the coming rising edge
    task automatic step(input string tag);
        bit to, er, ew, ek;
        to = 1'b0;
        if (!rst_n || !wdt_en) cnt = 0;
        else if (clrwd_stb || sleep_stb || (clk_lost && fscm_en) || freq_wr_stb) cnt = 0;
        else if (lf_tick) begin
            if (fires(cnt, int'(ps_sel))) begin cnt = 0; to = 1'b1; end
            else cnt++;
        end
        er = rst_n && to && (pm_mode == 2'b00);
        ew = rst_n && to && (pm_mode != 2'b00);
        ek = rst_n && (wdt_en || fscm_en);
        @(posedge clk); #1;
        chk(tag, "wdt_rst_req", wdt_rst_req, er);
        chk(tag, "wake_req", wake_req, ew);
        chk(tag, "lf_keep_on", lf_keep_on, ek);
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        lf_tick = 1'b1;
        for (int i = 0; i < n; i++) step(tag);
        lf_tick = 1'b0;
    endtask

    task automatic pulse_clear(input int which, input string tag);
        case (which)
            0: clrwd_stb = 1'b1;
            1: sleep_stb = 1'b1;
            2: clk_lost = 1'b1;
            default: freq_wr_stb = 1'b1;
        endcase
        step(tag);
        clrwd_stb = 1'b0; sleep_stb = 1'b0; clk_lost = 1'b0; freq_wr_stb = 1'b0;
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'd2718);
        @(negedge clk);
        // R1: held in reset
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1'b1;
        step("R1");
        // R13: keep output follows the enables
        fscm_en = 1'b1; step("R13"); step("R13");
        fscm_en = 1'b0; step("R13");
        // R2 / R3: run mode, ratio 1 then 4
        wdt_en = 1'b1; pm_mode = 2'b00; ps_sel = 4'd0;
        run(40, "R3");
        ps_sel = 4'd2; pulse_clear(0, "R2");
        lf_tick = 1'b0; for (int i = 0; i < 5; i++) step("R2");
        run(70, "R2");
        // R4: idle-class modes produce wake
        pm_mode = 2'b10; ps_sel = 4'd1; pulse_clear(0, "R4");
        run(40, "R4");
        pm_mode = 2'b11; ps_sel = 4'd0; run(20, "R4");
        pm_mode = 2'b01; run(20, "R4");
        // R5: restart after time-out
        pm_mode = 2'b00; run(33, "R5");
        // R6, R7, R9 clears
        pulse_clear(0, "R6"); run(10, "R6"); pulse_clear(0, "R6"); run(20, "R6");
        run(5, "R7"); pulse_clear(1, "R7"); run(20, "R7");
        run(7, "R9"); pulse_clear(3, "R9"); run(20, "R9");
        // R8: clock loss honoured only with the monitor on
        pulse_clear(0, "R8"); run(10, "R8");
        fscm_en = 1'b1; pulse_clear(2, "R8"); run(10, "R8");
        fscm_en = 1'b0; pulse_clear(2, "R8"); run(8, "R8");
        // R10: clear on the time-out tick
        pulse_clear(0, "R10"); run(15, "R10");
        lf_tick = 1'b1; pulse_clear(0, "R10"); lf_tick = 1'b0;
        run(17, "R10");
        // R11: disabled holds zero
        run(9, "R11");
        wdt_en = 1'b0; run(40, "R11");
        wdt_en = 1'b1; run(20, "R11");
        // R12: lowering the ratio mid-count
        ps_sel = 4'd3; pulse_clear(0, "R12"); run(70, "R12");
        ps_sel = 4'd1; run(20, "R12");
        // large ratio does not fire early (R2)
        ps_sel = 4'd15; pulse_clear(0, "R2"); run(300, "R2");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            lf_tick     = ($urandom % 2) == 0;
            pm_mode     = 2'($urandom % 4);
            ps_sel      = 4'($urandom % 3);
            wdt_en      = ($urandom % 50) != 0;
            fscm_en     = ($urandom % 2) == 0;
            clrwd_stb   = ($urandom % 60) == 0;
            sleep_stb   = ($urandom % 80) == 0;
            clk_lost    = ($urandom % 50) == 0;
            freq_wr_stb = ($urandom % 90) == 0;
            step("R2");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule